// File: doc/BRIEF.md
# Eleven-Level Nearest-Level Gate Pattern Generator

This block drives the ten gate lines of a dual-source, switched-capacitor eleven-level inverter leg. A prescaler produces a sample tick. On each tick a phase accumulator moves forward by a programmable increment, and the top bits of the accumulator address a quarter-wave sine table. The sine magnitude is multiplied by an unsigned modulation index and rounded to the nearest whole output level. Levels run from -5 to +5, and one level step equals half of the unit source voltage.

The level code selects a gate pattern. Positive levels and zero use a pattern table fixed by the power stage. Negative levels use a second table, which is an elaboration parameter; by default it mirrors the positive table. The three complementary switch pairs pass through dead-time cells. Each cell keeps both switches of a pair off for a set number of clock cycles before either one turns on. With enable low, every gate is held off.

Top module: `nlc_gate_gen`

## Requirements
- R1: While reset is asserted, all ten gate lines are low and the level code is 0.
- R2: While enable is low, all gate lines are low in the same cycle, the level code returns to 0 at the next clock edge, and the prescaler and phase restart from zero.
- R3: The level code changes only on a sample tick. The first tick comes PRESC_DIV clock edges after enable rises, and tick k samples phase k*phaseInc. The sine index is the top 8 bits of the 16-bit phase.
- R4: For sine index n (0 to 255), the magnitude is round(32767*|sin(2*pi*(n+0.5)/256)|). The sign is negative for n >= 128. The level magnitude is floor((5*magnitude*modIndex + 2^29) / 2^30), limited to 5, so rounding is half away from zero.
- R5: modIndex is unsigned Q1.15 (32768 = 1.0). Indices of 0.92 and 1.0 reach all eleven levels. Indices of 0.8 and 0.9 reach only nine levels, with a peak of 4.
- R6: Gate bit i drives switch S(i+1). Positive and zero levels switch on: 0 -> S1,S4,S5,S7; 1 -> S1,S4,S5,S8; 2 -> S1,S3,S5,S7; 3 -> S1,S3,S5,S8; 4 -> S1,S3,S6,S8; 5 -> S1,S3,S8,S9. All other switches are off.
- R7: By default, negative levels switch on: -1 -> S2,S3,S5,S8; -2 -> S2,S4,S5,S7; -3 -> S2,S4,S5,S8; -4 -> S2,S4,S6,S8; -5 -> S2,S4,S8,S10.
- R8: The pairs S1/S2, S3/S4 and S7/S8 are never on together.
- R9: A pair switch rises only after both switches of the pair have been off for at least DEAD_CYC cycles. The single switches S5, S6, S9 and S10 follow the level one clock after it changes.
- R10: With phaseInc = 256, the 256 levels of one period satisfy level[k+128] = -level[k] and level[127-k] = level[k].
- R11: levelCode is a 4-bit two's complement value and always lies in -5..+5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run enable; low forces all gates off |
| phaseInc | input | 16 | Phase step added on each sample tick |
| modIndex | input | 16 | Modulation index, unsigned Q1.15 |
| gates | output | 10 | Gate lines, bit i drives switch S(i+1) |
| levelCode | output | 4 | Current level, two's complement -5..+5 |

## Verification
The embedded properties assume that a pattern table never asks for both switches of a complementary pair, that DEAD_CYC is at least one, and that the prescaler period is longer than a pair turn-around. Only under those conditions do exclusivity and gap timing follow from the cells. The stimulus uses the default tables with a short prescaler of 8 and a dead time of 2. It changes enable and modIndex only at falling edges, and it holds enable low for several cycles so that pair gaps restart cleanly. Modulation indices stay within 0..1.0, so the limit at level 5 is reached but never needed to clip a larger value.

// File: rtl/nlc_pkg.sv
package nlc_pkg;
  localparam int NUM_GATES = 10;
  localparam int LVL_MAX   = 5;
  localparam int MI_W      = 16;
  localparam int SIN_W     = 15;

  typedef logic [NUM_GATES-1:0] gate_t;

  typedef struct packed {
    logic active;
    logic sampleTick;
  } strobe_t;

  // bit i drives switch S(i+1)
  function automatic gate_t posPattern(input logic [3:0] mag);
    case (mag)
      4'd0:    return 10'b00_0101_1001;
      4'd1:    return 10'b00_1001_1001;
      4'd2:    return 10'b00_0101_0101;
      4'd3:    return 10'b00_1001_0101;
      4'd4:    return 10'b00_1010_0101;
      4'd5:    return 10'b01_1000_0101;
      default: return '0;
    endcase
  endfunction

  function automatic gate_t mirrorGate(input gate_t g);
    gate_t r;
    r    = g;
    r[0] = g[1];
    r[1] = g[0];
    r[2] = g[3];
    r[3] = g[2];
    r[8] = g[9];
    r[9] = g[8];
    return r;
  endfunction

  function automatic logic [LVL_MAX*NUM_GATES-1:0] defaultNegTable();
    logic [LVL_MAX*NUM_GATES-1:0] t;
    t = '0;
    for (int m = 1; m <= LVL_MAX; m++)
      t[(m-1)*NUM_GATES +: NUM_GATES] = mirrorGate(posPattern(4'(m)));
    return t;
  endfunction
endpackage

// File: rtl/nlc_ctrl.sv
module nlc_ctrl
  import nlc_pkg::*;
#(
  parameter int PRESC_DIV = 15625,
  parameter int ACC_W     = 16,
  parameter int IDX_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [ACC_W-1:0] phaseInc,
  output strobe_t          strb,
  output logic [IDX_W-1:0] phaseIdx
);
  localparam int PW = (PRESC_DIV > 1) ? $clog2(PRESC_DIV) : 1;

  logic [PW-1:0]    divCnt;
  logic [ACC_W-1:0] acc;
  logic             tick;

  assign tick = enable && (divCnt == PW'(PRESC_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      divCnt <= '0;
      acc    <= '0;
    end else if (!enable) begin
      divCnt <= '0;
      acc    <= '0;
    end else if (tick) begin
      divCnt <= '0;
      acc    <= acc + phaseInc;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  assign strb.active     = enable;
  assign strb.sampleTick = tick;
  assign phaseIdx        = acc[ACC_W-1 -: IDX_W];

  // R3: phase holds between ticks
  p_idx_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !tick) |=> $stable(phaseIdx));

  // R3: ticks are spaced by the prescaler
  p_tick_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((PRESC_DIV > 1) && tick) |=> !tick);
endmodule

// File: rtl/nlc_deadtime.sv
module nlc_deadtime #(
  parameter int DEAD_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wantA,
  input  logic wantB,
  output logic gateA,
  output logic gateB
);
  localparam int CW = (DEAD_CYC > 0) ? $clog2(DEAD_CYC + 1) : 1;

  logic [CW-1:0] offCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gateA  <= 1'b0;
      gateB  <= 1'b0;
      offCnt <= CW'(DEAD_CYC);
    end else if (gateA && !wantA) begin
      gateA  <= 1'b0;
      offCnt <= '0;
    end else if (gateB && !wantB) begin
      gateB  <= 1'b0;
      offCnt <= '0;
    end else if (!gateA && !gateB) begin
      if (offCnt >= CW'(DEAD_CYC - 1)) begin
        gateA <= wantA;
        gateB <= wantB && !wantA;
      end
      if (offCnt != CW'(DEAD_CYC)) offCnt <= offCnt + 1'b1;
    end
  end

  // checker-side gap counter
  logic [CW-1:0] gapSeen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                gapSeen <= CW'(DEAD_CYC);
    else if (gateA || gateB)   gapSeen <= '0;
    else if (gapSeen != CW'(DEAD_CYC)) gapSeen <= gapSeen + 1'b1;
  end

  p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(gateA && gateB));

  p_gap_a_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gateA) |-> (gapSeen >= CW'(DEAD_CYC)));

  p_gap_b_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gateB) |-> (gapSeen >= CW'(DEAD_CYC)));
endmodule

// File: rtl/nlc_datapath.sv
module nlc_datapath
  import nlc_pkg::*;
#(
  parameter int QTR_BITS = 6,
  parameter int DEAD_CYC = 20,
  parameter logic [LVL_MAX*NUM_GATES-1:0] NEG_TABLE = defaultNegTable()
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  strobe_t               strb,
  input  logic [QTR_BITS+1:0]   phaseIdx,
  input  logic [MI_W-1:0]       modIndex,
  output logic [NUM_GATES-1:0]  gates,
  output logic signed [3:0]     levelCode
);
  localparam int QN    = 1 << QTR_BITS;
  localparam int IDX_W = QTR_BITS + 2;
  localparam int PR_W  = SIN_W + MI_W;
  localparam int SC_W  = PR_W + 3;
  localparam int FRAC  = PR_W - 1;

  // quarter-wave sine, half-sample offset
  logic [SIN_W-1:0] qRom [QN];
  for (genvar g = 0; g < QN; g++) begin : g_rom
    localparam real ANG = (real'(g) + 0.5) * 3.14159265358979 / (2.0 * real'(QN));
    assign qRom[g] = SIN_W'($rtoi(32767.0 * $sin(ANG) + 0.5));
  end

  logic                neg, mirror;
  logic [QTR_BITS-1:0] qAddr;
  logic [SIN_W-1:0]    sinMag;
  logic [PR_W-1:0]     prod;
  logic [SC_W-1:0]     scaled;
  logic [3:0]          rndMag, clampMag;
  logic signed [3:0]   nextLevel;

  assign neg      = phaseIdx[IDX_W-1];
  assign mirror   = phaseIdx[IDX_W-2];
  assign qAddr    = mirror ? ~phaseIdx[QTR_BITS-1:0] : phaseIdx[QTR_BITS-1:0];
  assign sinMag   = qRom[qAddr];
  assign prod     = PR_W'(sinMag) * PR_W'(modIndex);
  assign scaled   = SC_W'(prod) * SC_W'(LVL_MAX) + (SC_W'(1) << (FRAC - 1));
  assign rndMag   = scaled[SC_W-1 -: 4];
  assign clampMag = (rndMag > 4'(LVL_MAX)) ? 4'(LVL_MAX) : rndMag;
  assign nextLevel = (neg && clampMag != 4'd0) ? -$signed(clampMag) : $signed(clampMag);

  logic signed [3:0] levelQ;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               levelQ <= '0;
    else if (!strb.active)    levelQ <= '0;
    else if (strb.sampleTick) levelQ <= nextLevel;
  end
  assign levelCode = levelQ;

  // pattern selection
  logic [3:0] absLvl;
  gate_t      pattern, want;
  assign absLvl = levelQ[3] ? 4'(-levelQ) : 4'(levelQ);

  always_comb begin
    pattern = posPattern(absLvl);
    if (levelQ[3]) begin
      pattern = '0;
      for (int m = 1; m <= LVL_MAX; m++)
        if (absLvl == 4'(m)) pattern = NEG_TABLE[(m-1)*NUM_GATES +: NUM_GATES];
    end
  end
  assign want = strb.active ? pattern : '0;

  // complementary pairs with dead time
  localparam int PAIR_LO [3] = '{0, 2, 6};
  logic [2:0] pairA, pairB;
  for (genvar p = 0; p < 3; p++) begin : g_pair
    nlc_deadtime #(.DEAD_CYC(DEAD_CYC)) u_dt (
      .clk   (clk),
      .rst_n (rst_n),
      .wantA (want[PAIR_LO[p]]),
      .wantB (want[PAIR_LO[p] + 1]),
      .gateA (pairA[p]),
      .gateB (pairB[p])
    );
  end

  // single switches: S5, S6, S9, S10
  logic [3:0] singleQ;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) singleQ <= '0;
    else        singleQ <= {want[9], want[8], want[5], want[4]};
  end

  gate_t gateAll;
  assign gateAll = {singleQ[3], singleQ[2], pairB[2], pairA[2], singleQ[1], singleQ[0],
                    pairB[1], pairA[1], pairB[0], pairA[0]};
  assign gates   = strb.active ? gateAll : '0;

  p_level_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (levelCode >= -4'sd5) && (levelCode <= 4'sd5));

  p_level_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.active && !strb.sampleTick) |=> $stable(levelCode));

  p_no_shoot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(gates[0] && gates[1]) && !(gates[2] && gates[3]) && !(gates[6] && gates[7]));
endmodule

// File: rtl/nlc_gate_gen.sv
module nlc_gate_gen
  import nlc_pkg::*;
#(
  parameter int PRESC_DIV = 15625,
  parameter int ACC_W     = 16,
  parameter int QTR_BITS  = 6,
  parameter int DEAD_CYC  = 20,
  parameter logic [LVL_MAX*NUM_GATES-1:0] NEG_TABLE = defaultNegTable()
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic [ACC_W-1:0]     phaseInc,
  input  logic [MI_W-1:0]      modIndex,
  output logic [NUM_GATES-1:0] gates,
  output logic [3:0]           levelCode
);
  localparam int IDX_W = QTR_BITS + 2;

  strobe_t           strb;
  logic [IDX_W-1:0]  phaseIdx;
  logic signed [3:0] lvl;

  nlc_ctrl #(.PRESC_DIV(PRESC_DIV), .ACC_W(ACC_W), .IDX_W(IDX_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .phaseInc (phaseInc),
    .strb     (strb),
    .phaseIdx (phaseIdx)
  );

  nlc_datapath #(.QTR_BITS(QTR_BITS), .DEAD_CYC(DEAD_CYC), .NEG_TABLE(NEG_TABLE)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strb      (strb),
    .phaseIdx  (phaseIdx),
    .modIndex  (modIndex),
    .gates     (gates),
    .levelCode (lvl)
  );

  assign levelCode = lvl;
endmodule

// File: tb/sim_nlc_gate_gen.sv
`timescale 1ns/1ps
module sim_nlc_gate_gen;
  localparam int DIV = 8;
  localparam int DT  = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [15:0] phaseInc = 16'd256;
  logic [15:0] modIndex = 16'd32768;
  logic [9:0]  gates;
  logic [3:0]  levelCode;

  always #2.5 clk = ~clk;

  nlc_gate_gen #(.PRESC_DIV(DIV), .DEAD_CYC(DT)) u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .phaseInc(phaseInc),
    .modIndex(modIndex), .gates(gates), .levelCode(levelCode)
  );

  int nRun = 0, nFail = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int expLevel(input int idx, input int mi);
    real s;
    int mag, m;
    longint p;
    s   = 32767.0 * $sin((real'(idx) + 0.5) * 2.0 * 3.14159265358979 / 256.0);
    mag = $rtoi(((s < 0.0) ? -s : s) + 0.5);
    p   = longint'(mag) * longint'(mi) * 5 + (longint'(1) << 29);
    m   = int'(p >>> 30);
    if (m > 5) m = 5;
    return (s < 0.0) ? -m : m;
  endfunction

  // R6/R7 switch lists, S(n) -> bit n-1
  function automatic int expGates(input int lvl);
    case (lvl)
      0:  return (1<<0)|(1<<3)|(1<<4)|(1<<6);
      1:  return (1<<0)|(1<<3)|(1<<4)|(1<<7);
      2:  return (1<<0)|(1<<2)|(1<<4)|(1<<6);
      3:  return (1<<0)|(1<<2)|(1<<4)|(1<<7);
      4:  return (1<<0)|(1<<2)|(1<<5)|(1<<7);
      5:  return (1<<0)|(1<<2)|(1<<7)|(1<<8);
      -1: return (1<<1)|(1<<2)|(1<<4)|(1<<7);
      -2: return (1<<1)|(1<<3)|(1<<4)|(1<<6);
      -3: return (1<<1)|(1<<3)|(1<<4)|(1<<7);
      -4: return (1<<1)|(1<<3)|(1<<5)|(1<<7);
      -5: return (1<<1)|(1<<3)|(1<<7)|(1<<9);
      default: return -1;
    endcase
  endfunction

  // pair monitor: R8 exclusivity, R9 gap
  localparam int PA [3] = '{0, 2, 6};
  int  gap [3] = '{1000, 1000, 1000};
  bit  prevA [3] = '{0, 0, 0};
  bit  prevB [3] = '{0, 0, 0};
  int  overlapErr = 0, gapErr = 0;
  always @(negedge clk) begin
    for (int p = 0; p < 3; p++) begin
      automatic bit a = gates[PA[p]];
      automatic bit b = gates[PA[p]+1];
      if (a && b) overlapErr++;
      if ((a && !prevA[p]) || (b && !prevB[p]))
        if (gap[p] < DT) gapErr++;
      if (a || b) gap[p] = 0;
      else if (gap[p] < 1000) gap[p]++;
      prevA[p] = a;
      prevB[p] = b;
    end
  end

  localparam int NV = 5;
  localparam int VMI  [NV] = '{32768, 30147, 29491, 26214, 0};
  localparam int VPK  [NV] = '{5, 5, 4, 4, 0};
  localparam int VCNT [NV] = '{11, 11, 9, 9, 1};

  int periodLvl [256];

  task automatic restart(input int mi, input int inc);
    @(negedge clk);
    enable = 1'b0;
    modIndex = 16'(mi);
    phaseInc = 16'(inc);
    repeat (4) @(negedge clk);
    enable = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(gates == 10'd0, "R1 gates in reset", int'(gates), 0);
    chk(levelCode == 4'd0, "R1 level in reset", int'(levelCode), 0);
    rst_n = 1'b1;

    // vector table walk
    for (int v = 0; v < NV; v++) begin
      automatic bit seen [11];
      automatic int cnt = 0, peak = 0;
      for (int j = 0; j < 11; j++) seen[j] = 0;
      restart(VMI[v], 256);
      if (v == 0) begin
        repeat (DIV/2) @(posedge clk);
        #1 chk(levelCode == 4'd0, "R3 no tick yet", int'($signed(levelCode)), 0);
        repeat (DIV/2) @(posedge clk);
      end else begin
        repeat (DIV) @(posedge clk);
      end
      for (int k = 0; k < 256; k++) begin
        automatic int el, al;
        if (k != 0) repeat (DIV/2) @(posedge clk);
        #1;
        el = expLevel(k, VMI[v]);
        al = int'($signed(levelCode));
        chk(al == el, "R4 R5 R11 level", al, el);
        periodLvl[k] = al;
        if (!seen[al+5]) begin seen[al+5] = 1; cnt++; end
        if (al > peak) peak = al;
        repeat (DIV/2) @(posedge clk);
        #1 chk(int'(gates) == expGates(el), (el < 0) ? "R7 R9 gates" : "R6 R9 gates",
               int'(gates), expGates(el));
      end
      chk(cnt == VCNT[v], "R5 distinct levels", cnt, VCNT[v]);
      chk(peak == VPK[v], "R5 peak level", peak, VPK[v]);
      if (v == 0)
        for (int k = 0; k < 128; k++) begin
          chk(periodLvl[k+128] == -periodLvl[k], "R10 half-wave antisymmetry",
              periodLvl[k+128], -periodLvl[k]);
          chk(periodLvl[127-k] == periodLvl[k], "R10 quarter mirror",
              periodLvl[127-k], periodLvl[k]);
        end
    end

    // doubled phase step
    restart(32768, 512);
    repeat (DIV) @(posedge clk);
    for (int k = 0; k < 20; k++) begin
      if (k != 0) repeat (DIV) @(posedge clk);
      #1 chk(int'($signed(levelCode)) == expLevel((2*k) % 256, 32768), "R3 phase step 512",
             int'($signed(levelCode)), expLevel((2*k) % 256, 32768));
    end

    // enable drop mid-run
    repeat (3) @(posedge clk);
    @(negedge clk);
    enable = 1'b0;
    #1 chk(gates == 10'd0, "R2 gates off at once", int'(gates), 0);
    @(posedge clk);
    #1 chk(levelCode == 4'd0, "R2 level cleared", int'($signed(levelCode)), 0);
    repeat (4) @(negedge clk);
    chk(gates == 10'd0, "R2 gates stay off", int'(gates), 0);
    enable = 1'b1;
    repeat (DIV) @(posedge clk);
    #1 chk(int'($signed(levelCode)) == expLevel(0, 32768), "R2 R3 phase restart",
           int'($signed(levelCode)), expLevel(0, 32768));
    repeat (DIV) @(posedge clk);
    #1 chk(int'($signed(levelCode)) == expLevel(2, 32768), "R3 second tick",
           int'($signed(levelCode)), expLevel(2, 32768));

    // reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1 chk(gates == 10'd0, "R1 async reset gates", int'(gates), 0);
    chk(levelCode == 4'd0, "R1 async reset level", int'($signed(levelCode)), 0);
    @(negedge clk);
    rst_n = 1'b1;

    chk(overlapErr == 0, "R8 pair overlap events", overlapErr, 0);
    chk(gapErr == 0, "R9 short dead-time events", gapErr, 0);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nRun++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule